// File: doc/BRIEF.md
# Two-Stage Routed Interrupt Controller

This block collects a set of system event lines and turns them into a smaller set of host interrupt lines. Routing is programmable and takes two steps. First, every event is assigned to a channel. Then every channel is assigned to a host output. Each event has its own polarity and its own trigger kind, level or edge. Each event also has a latched pending bit and an enable bit. Both bits can be changed one event at a time by writing an event number, or many at once by writing a 32-bit mask.

Software uses a single 32-bit register port with word addresses. It programs the two routing tables, enables events and hosts, and sets the global enable. While serving a host line, software reads that host's priority-index register to find the event to handle next. Bit 31 of that register reports that nothing is pending for the host. The channel number gives the priority: lower channels come first, and inside one channel lower event numbers come first.

Top module: `intc_two_stage`

## Requirements
- R1: After a synchronous reset, the following hold. All pending bits, enable bits, routing fields, host enables, the global enable and all host outputs are 0. Every polarity bit is 1 (active high). Every type bit is 0 (level). Every priority-index register reads 0x8000_0000.
- R2: The event-to-channel table sits at word addresses 0x20 + e/4. Event e uses bits [8*(e%4)+3 : 8*(e%4)], which hold its channel number. The other bits of each byte read as 0.
- R3: The channel-to-host table sits at word addresses 0x30 + c/4. Channel c uses bits [8*(c%4)+3 : 8*(c%4)], which hold its host number. A channel or host number of N_CH or more routes nowhere.
- R4: The following word addresses take an event number. Writing it to 0x01 sets the event's pending bit, and writing it to 0x02 clears it. Writing it to 0x03 sets the event's enable bit, and writing it to 0x04 clears it. A value of N_EVT or more changes nothing.
- R5: For group g (events 32g to 32g+31), the following mask registers apply. 0x10+g reads the pending bits. 0x12+g clears pending bits where a 1 is written, and reads the pending bits. 0x14+g sets enable bits where a 1 is written. 0x16+g clears enable bits where a 1 is written. Both 0x14+g and 0x16+g read the enable bits.
- R6: Writing a host number to 0x05 enables that host output. Writing it to 0x06 disables it. A value of N_CH or more is ignored.
- R7: Bit 0 of word 0x00 is the global enable. While it is 0, no host output asserts.
- R8: Word 0x40+h reads 0x8000_0000 when no event that is both pending and enabled routes to host h. Otherwise bits 9:0 hold the winning event: the lowest channel first, then the lowest event number within that channel.
- R9: The polarity bits are at 0x18+g (1 = active high) and the type bits are at 0x1A+g (0 = level, 1 = edge). In level mode the pending bit is set on every cycle that the input is active. In edge mode it is set only on a change from inactive to active. A set from the input wins over a clear written in the same cycle.
- R10: Host output h is a register. It is high when, in the previous cycle, three things held: the global enable was on, host h was enabled, and an event that was both pending and enabled routed to host h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | N_EVT (64) | Raw system event lines |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered one cycle after the address |
| host_irq | output | N_CH (10) | Registered host interrupt lines |

## Verification
The checker tests four properties on every cycle. A host line can assert only when the global enable and that host's enable were set in the cycle before. Any active level-mode input is pending one cycle later. An index write to the enable-set register always takes effect. The host outputs are low after reset. The other behaviours can only be shown by the bench scenarios, where a behavioural model is compared with the outputs on every clock. Those behaviours are the two-level priority order, the edge latching against level re-setting, the polarity inversion, the packing of the table lanes, and the rejection of out-of-range index writes.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int MAP_W  = 4;

  // word addresses of the register port
  localparam logic [7:0] A_GEN  = 8'h00;
  localparam logic [7:0] A_SSET = 8'h01;
  localparam logic [7:0] A_SCLR = 8'h02;
  localparam logic [7:0] A_ESET = 8'h03;
  localparam logic [7:0] A_ECLR = 8'h04;
  localparam logic [7:0] A_HSET = 8'h05;
  localparam logic [7:0] A_HCLR = 8'h06;
  localparam logic [7:0] A_RAW  = 8'h10;
  localparam logic [7:0] A_SW1C = 8'h12;
  localparam logic [7:0] A_EW1S = 8'h14;
  localparam logic [7:0] A_EW1C = 8'h16;
  localparam logic [7:0] A_POL  = 8'h18;
  localparam logic [7:0] A_TYP  = 8'h1A;
  localparam logic [7:0] A_CMAP = 8'h20;
  localparam logic [7:0] A_HMAP = 8'h30;
  localparam logic [7:0] A_PRIO = 8'h40;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/intc_evt_group.sv
// One group of 32 events: polarity, trigger kind, pending and enable state.
module intc_evt_group #(
  parameter int GW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] evt_in,
  input  logic          pol_we,
  input  logic          typ_we,
  input  logic [GW-1:0] wr_data,
  input  logic [GW-1:0] sw_set,
  input  logic [GW-1:0] sw_clr,
  input  logic [GW-1:0] en_set,
  input  logic [GW-1:0] en_clr,
  output logic [GW-1:0] pol_q,
  output logic [GW-1:0] typ_q,
  output logic [GW-1:0] stat_q,
  output logic [GW-1:0] en_q,
  output logic [GW-1:0] act
);
  logic [GW-1:0] prev_q;
  logic [GW-1:0] hw_set;

  // polarity 1 passes the line, polarity 0 inverts it
  assign act    = ~(evt_in ^ pol_q);
  assign hw_set = (act & ~typ_q) | (act & ~prev_q & typ_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '1;
      typ_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
      prev_q <= '0;
    end else begin
      if (pol_we) pol_q <= wr_data;
      if (typ_we) typ_q <= wr_data;
      prev_q <= act;
      stat_q <= (stat_q & ~sw_clr) | sw_set | hw_set;
      en_q   <= (en_q & ~en_clr) | en_set;
    end
  end
endmodule

// File: rtl/intc_chan_pick.sv
// For each channel: is any routed event pending, and which is the lowest.
module intc_chan_pick #(
  parameter int N_EVT = 64,
  parameter int N_CH  = 10,
  parameter int EVT_W = 6,
  parameter int MW    = 4
) (
  input  logic [N_EVT-1:0]             pend,
  input  logic [N_EVT-1:0][MW-1:0]     cmap,
  output logic [N_CH-1:0]              ch_hit,
  output logic [N_CH-1:0][EVT_W-1:0]   ch_evt
);
  always_comb begin
    ch_hit = '0;
    ch_evt = '0;
    for (int c = 0; c < N_CH; c++) begin
      for (int e = N_EVT - 1; e >= 0; e--) begin
        if (pend[e] && (cmap[e] == MW'(c))) begin
          ch_hit[c] = 1'b1;
          ch_evt[c] = EVT_W'(e);
        end
      end
    end
  end
endmodule

// File: rtl/intc_host_pick.sv
// For each host: the lowest active channel routed to it decides the event.
module intc_host_pick #(
  parameter int N_CH  = 10,
  parameter int EVT_W = 6,
  parameter int MW    = 4
) (
  input  logic [N_CH-1:0]            ch_hit,
  input  logic [N_CH-1:0][EVT_W-1:0] ch_evt,
  input  logic [N_CH-1:0][MW-1:0]    hmap,
  output logic [N_CH-1:0]            h_hit,
  output logic [N_CH-1:0][EVT_W-1:0] h_evt
);
  always_comb begin
    h_hit = '0;
    h_evt = '0;
    for (int h = 0; h < N_CH; h++) begin
      for (int c = N_CH - 1; c >= 0; c--) begin
        if (ch_hit[c] && (hmap[c] == MW'(h))) begin
          h_hit[h] = 1'b1;
          h_evt[h] = ch_evt[c];
        end
      end
    end
  end
endmodule

// File: rtl/intc_two_stage.sv
module intc_two_stage
  import intc_pkg::*;
#(
  parameter int N_EVT = 64,
  parameter int N_CH  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_CH-1:0]   host_irq
);
  localparam int NGRP   = N_EVT / 32;
  localparam int EVT_W  = $clog2(N_EVT);
  localparam int HOST_W = $clog2(N_CH);
  localparam int NCMAP  = (N_EVT + 3) / 4;
  localparam int NHMAP  = (N_CH + 3) / 4;

  logic                         gen_q;
  logic [N_CH-1:0]              hen_q;
  logic [N_CH-1:0]              host_q;
  logic [N_EVT-1:0][MAP_W-1:0]  cmap_q;
  logic [N_CH-1:0][MAP_W-1:0]   hmap_q;
  logic [N_EVT-1:0]             stat_q, en_q, pol_q, typ_q, act, pend;
  logic [N_EVT-1:0]             s_set, s_clr, e_set, e_clr;
  logic [NGRP-1:0]              pol_we, typ_we;
  logic                         evt_ok, host_ok;
  logic [N_EVT-1:0]             evt_onehot;
  logic [N_CH-1:0]              host_onehot;
  logic [N_CH-1:0]              ch_hit, h_hit;
  logic [N_CH-1:0][EVT_W-1:0]   ch_evt, h_evt;
  word_t                        rd_val;

  // index decode for the write-a-number registers
  assign evt_ok      = reg_wdata < 32'(N_EVT);
  assign host_ok     = reg_wdata < 32'(N_CH);
  assign evt_onehot  = evt_ok  ? (N_EVT'(1) << reg_wdata[EVT_W-1:0]) : '0;
  assign host_onehot = host_ok ? (N_CH'(1) << reg_wdata[HOST_W-1:0]) : '0;

  always_comb begin
    s_set  = (reg_we && reg_addr == A_SSET) ? evt_onehot : '0;
    s_clr  = (reg_we && reg_addr == A_SCLR) ? evt_onehot : '0;
    e_set  = (reg_we && reg_addr == A_ESET) ? evt_onehot : '0;
    e_clr  = (reg_we && reg_addr == A_ECLR) ? evt_onehot : '0;
    pol_we = '0;
    typ_we = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (reg_we && reg_addr == 8'(A_SW1C + g)) s_clr[32*g +: 32] = s_clr[32*g +: 32] | reg_wdata;
      if (reg_we && reg_addr == 8'(A_EW1S + g)) e_set[32*g +: 32] = e_set[32*g +: 32] | reg_wdata;
      if (reg_we && reg_addr == 8'(A_EW1C + g)) e_clr[32*g +: 32] = e_clr[32*g +: 32] | reg_wdata;
      pol_we[g] = reg_we && reg_addr == 8'(A_POL + g);
      typ_we[g] = reg_we && reg_addr == 8'(A_TYP + g);
    end
  end

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      intc_evt_group #(.GW(32)) u_grp (
        .clk     (clk),
        .rst     (rst),
        .evt_in  (evt_in[32*g +: 32]),
        .pol_we  (pol_we[g]),
        .typ_we  (typ_we[g]),
        .wr_data (reg_wdata),
        .sw_set  (s_set[32*g +: 32]),
        .sw_clr  (s_clr[32*g +: 32]),
        .en_set  (e_set[32*g +: 32]),
        .en_clr  (e_clr[32*g +: 32]),
        .pol_q   (pol_q[32*g +: 32]),
        .typ_q   (typ_q[32*g +: 32]),
        .stat_q  (stat_q[32*g +: 32]),
        .en_q    (en_q[32*g +: 32]),
        .act     (act[32*g +: 32])
      );
    end
  endgenerate

  // global enable, host enables and both routing tables
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q  <= 1'b0;
      hen_q  <= '0;
      cmap_q <= '0;
      hmap_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_GEN) gen_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_HSET) hen_q <= hen_q | host_onehot;
      if (reg_we && reg_addr == A_HCLR) hen_q <= hen_q & ~host_onehot;
      for (int e = 0; e < N_EVT; e++)
        if (reg_we && reg_addr == 8'(A_CMAP + e / 4))
          cmap_q[e] <= reg_wdata[8*(e%4) +: MAP_W];
      for (int c = 0; c < N_CH; c++)
        if (reg_we && reg_addr == 8'(A_HMAP + c / 4))
          hmap_q[c] <= reg_wdata[8*(c%4) +: MAP_W];
    end
  end

  assign pend = stat_q & en_q;

  intc_chan_pick #(.N_EVT(N_EVT), .N_CH(N_CH), .EVT_W(EVT_W), .MW(MAP_W)) u_chan (
    .pend   (pend),
    .cmap   (cmap_q),
    .ch_hit (ch_hit),
    .ch_evt (ch_evt)
  );

  intc_host_pick #(.N_CH(N_CH), .EVT_W(EVT_W), .MW(MAP_W)) u_host (
    .ch_hit (ch_hit),
    .ch_evt (ch_evt),
    .hmap   (hmap_q),
    .h_hit  (h_hit),
    .h_evt  (h_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) host_q <= '0;
    else     host_q <= {N_CH{gen_q}} & hen_q & h_hit;
  end
  assign host_irq = host_q;

  // read mux
  always_comb begin
    rd_val = '0;
    if (reg_addr == A_GEN) rd_val[0] = gen_q;
    for (int g = 0; g < NGRP; g++) begin
      if (reg_addr == 8'(A_RAW + g) || reg_addr == 8'(A_SW1C + g)) rd_val = stat_q[32*g +: 32];
      if (reg_addr == 8'(A_EW1S + g) || reg_addr == 8'(A_EW1C + g)) rd_val = en_q[32*g +: 32];
      if (reg_addr == 8'(A_POL + g)) rd_val = pol_q[32*g +: 32];
      if (reg_addr == 8'(A_TYP + g)) rd_val = typ_q[32*g +: 32];
    end
    for (int w = 0; w < NCMAP; w++)
      if (reg_addr == 8'(A_CMAP + w))
        for (int l = 0; l < 4; l++)
          if (4 * w + l < N_EVT) rd_val[8*l +: MAP_W] = cmap_q[4*w+l];
    for (int w = 0; w < NHMAP; w++)
      if (reg_addr == 8'(A_HMAP + w))
        for (int l = 0; l < 4; l++)
          if (4 * w + l < N_CH) rd_val[8*l +: MAP_W] = hmap_q[4*w+l];
    for (int h = 0; h < N_CH; h++)
      if (reg_addr == 8'(A_PRIO + h))
        rd_val = h_hit[h] ? 32'(h_evt[h]) : 32'h8000_0000;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_val;
  end
endmodule

// File: rtl/intc_two_stage_chk.sv
module intc_two_stage_chk
  import intc_pkg::*;
#(
  parameter int N_EVT = 64,
  parameter int N_CH  = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [7:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [N_CH-1:0]  host_irq,
  input logic             gen_q,
  input logic [N_CH-1:0]  hen_q,
  input logic [N_EVT-1:0] en_q,
  input logic [N_EVT-1:0] stat_q,
  input logic [N_EVT-1:0] act,
  input logic [N_EVT-1:0] typ_q
);
  localparam int EVT_W = $clog2(N_EVT);

  // R7
  glob_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (|host_irq) |-> $past(gen_q));

  // R6
  host_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((host_irq & ~$past(hen_q)) == '0));

  // R9
  level_set_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(act) & ~$past(typ_q)) & ~stat_q) == '0));

  // R4
  en_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_ESET && reg_wdata < 32'(N_EVT))
      |=> en_q[$past(reg_wdata[EVT_W-1:0])]);

  // R1
  rst_out_chk: assert property (@(posedge clk)
    rst |=> (host_irq == '0));
endmodule

bind intc_two_stage intc_two_stage_chk #(.N_EVT(N_EVT), .N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .host_irq  (host_irq),
  .gen_q     (gen_q),
  .hen_q     (hen_q),
  .en_q      (en_q),
  .stat_q    (stat_q),
  .act       (act),
  .typ_q     (typ_q)
);

// File: tb/intc_two_stage_bench.sv
`timescale 1ns/1ps
module intc_two_stage_bench;
  localparam int NE = 64;
  localparam int NC = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] evt_in = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = 8'h00;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] host_irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  intc_two_stage #(.N_EVT(NE), .N_CH(NC)) u_intc_two_stage (
    .clk(clk), .rst(rst), .evt_in(evt_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [NE-1:0] m_stat, m_en, m_pol, m_typ, m_prev;
  int          m_cmap [NE];
  int          m_hmap [NC];
  bit [NC-1:0] m_hen;
  bit          m_gen;
  bit [NC-1:0] m_irq;
  bit [31:0]   m_rdata;

  function automatic bit [31:0] m_prio(int h);
    for (int c = 0; c < NC; c++)
      if (m_hmap[c] == h)
        for (int e = 0; e < NE; e++)
          if (m_stat[e] && m_en[e] && m_cmap[e] == c) return 32'(e);
    return 32'h8000_0000;
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit [31:0] v = '0;
    int g = int'(a[0]);
    if (a == 8'h00) v[0] = m_gen;
    else if (a >= 8'h10 && a <= 8'h13) v = m_stat[32*g +: 32];
    else if (a >= 8'h14 && a <= 8'h17) v = m_en[32*g +: 32];
    else if (a >= 8'h18 && a <= 8'h19) v = m_pol[32*g +: 32];
    else if (a >= 8'h1A && a <= 8'h1B) v = m_typ[32*g +: 32];
    else if (a >= 8'h20 && a <= 8'h2F) begin
      for (int l = 0; l < 4; l++) v[8*l +: 4] = 4'(m_cmap[4*(a-8'h20)+l]);
    end else if (a >= 8'h30 && a <= 8'h32) begin
      for (int l = 0; l < 4; l++)
        if (4*(a-8'h30)+l < NC) v[8*l +: 4] = 4'(m_hmap[4*(a-8'h30)+l]);
    end else if (a >= 8'h40 && a < 8'h40 + NC) v = m_prio(int'(a - 8'h40));
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stat = '0; m_en = '0; m_pol = '1; m_typ = '0; m_prev = '0;
      foreach (m_cmap[i]) m_cmap[i] = 0;
      foreach (m_hmap[i]) m_hmap[i] = 0;
      m_hen = '0; m_gen = 0; m_irq = '0; m_rdata = '0;
    end else begin
      bit [NC-1:0] nirq;
      bit [NE-1:0] act, hw, sset, sclr;
      int g;
      for (int h = 0; h < NC; h++) nirq[h] = m_gen && m_hen[h] && !m_prio(h)[31];
      m_rdata = m_read(reg_addr);
      act = ~(evt_in ^ m_pol);
      hw = '0;
      for (int e = 0; e < NE; e++) hw[e] = m_typ[e] ? (act[e] && !m_prev[e]) : act[e];
      m_prev = act;
      sset = '0; sclr = '0;
      g = int'(reg_addr[0]);
      if (reg_we) begin
        if (reg_addr == 8'h01 && reg_wdata < NE) sset[reg_wdata] = 1'b1;
        if (reg_addr == 8'h02 && reg_wdata < NE) sclr[reg_wdata] = 1'b1;
        if (reg_addr == 8'h03 && reg_wdata < NE) m_en[reg_wdata] = 1'b1;
        if (reg_addr == 8'h04 && reg_wdata < NE) m_en[reg_wdata] = 1'b0;
        if (reg_addr == 8'h05 && reg_wdata < NC) m_hen[reg_wdata] = 1'b1;
        if (reg_addr == 8'h06 && reg_wdata < NC) m_hen[reg_wdata] = 1'b0;
        if (reg_addr == 8'h00) m_gen = reg_wdata[0];
        if (reg_addr == 8'h12 || reg_addr == 8'h13) sclr[32*g +: 32] = reg_wdata;
        if (reg_addr == 8'h14 || reg_addr == 8'h15) m_en[32*g +: 32] = m_en[32*g +: 32] | reg_wdata;
        if (reg_addr == 8'h16 || reg_addr == 8'h17) m_en[32*g +: 32] = m_en[32*g +: 32] & ~reg_wdata;
        if (reg_addr == 8'h18 || reg_addr == 8'h19) m_pol[32*g +: 32] = reg_wdata;
        if (reg_addr == 8'h1A || reg_addr == 8'h1B) m_typ[32*g +: 32] = reg_wdata;
        if (reg_addr >= 8'h20 && reg_addr <= 8'h2F)
          for (int l = 0; l < 4; l++) m_cmap[4*(reg_addr-8'h20)+l] = int'(reg_wdata[8*l +: 4]);
        if (reg_addr >= 8'h30 && reg_addr <= 8'h32)
          for (int l = 0; l < 4; l++)
            if (4*(reg_addr-8'h30)+l < NC) m_hmap[4*(reg_addr-8'h30)+l] = int'(reg_wdata[8*l +: 4]);
      end
      m_stat = (m_stat & ~sclr) | sset | hw;
      m_irq = nirq;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      n_tests++;
      if (host_irq !== m_irq) begin
        n_fail++;
        $display("FAIL R10 host_irq actual=%h expected=%h", host_irq, m_irq);
      end
      n_tests++;
      if (reg_rdata !== m_rdata) begin
        n_fail++;
        $display("FAIL R8 readback addr=%h actual=%h expected=%h", reg_addr, reg_rdata, m_rdata);
      end
    end
  end

  // ---------------- directed scenario ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired before the scenario ended");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 host_irq", 32'(host_irq), 32'h0);
    rd(8'h40, v); chk("R1 prio idle", v, 32'h8000_0000);
    rd(8'h18, v); chk("R1 polarity", v, 32'hFFFF_FFFF);
    rd(8'h1A, v); chk("R1 type", v, 32'h0);

    // R2 lane packing
    wr(8'h21, 32'hFFFF_FFFF);
    rd(8'h21, v); chk("R2 lane mask", v, 32'h0F0F_0F0F);
    wr(8'h21, 32'h0000_0200);
    rd(8'h21, v); chk("R2 event5 ch2", v, 32'h0000_0200);
    // R3 host map
    wr(8'h30, 32'h0003_0000);
    rd(8'h30, v); chk("R3 ch2 host3", v, 32'h0003_0000);

    wr(8'h05, 3);
    wr(8'h00, 1);
    wr(8'h03, 5);
    evt_in[5] = 1'b1;
    idle(3);
    chk("R10 host3 up", 32'(host_irq), 32'h008);
    rd(8'h43, v); chk("R8 event5", v, 32'd5);

    // lower channel wins over lower event
    wr(8'h2A, 32'h0000_0001);
    wr(8'h30, 32'h0003_0300);
    wr(8'h15, 32'h0000_0100);
    wr(8'h01, 40);
    idle(2);
    rd(8'h43, v); chk("R8 channel order", v, 32'd40);
    rd(8'h11, v); chk("R5 raw group1", v, 32'h0000_0100);
    rd(8'h15, v); chk("R5 enable group1", v, 32'h0000_0100);
    wr(8'h13, 32'h0000_0100);
    rd(8'h11, v); chk("R5 w1c", v, 32'h0);
    rd(8'h43, v); chk("R8 back to 5", v, 32'd5);

    // lower event wins within a channel
    wr(8'h20, 32'h0200_0000);
    wr(8'h03, 3);
    wr(8'h01, 3);
    rd(8'h43, v); chk("R8 event order", v, 32'd3);
    wr(8'h02, 3);
    rd(8'h43, v); chk("R4 idx clear", v, 32'd5);

    // R9 level input re-sets over a clear
    wr(8'h02, 5);
    rd(8'h10, v); chk("R9 level reset", v, 32'h0000_0020);
    // R9 edge mode
    wr(8'h1A, 32'h0000_0020);
    wr(8'h02, 5);
    rd(8'h10, v); chk("R9 edge no rise", v, 32'h0);
    idle(2);
    chk("R9 host drops", 32'(host_irq), 32'h0);
    evt_in[5] = 1'b0; idle(2);
    evt_in[5] = 1'b1; idle(2);
    evt_in[5] = 1'b0; idle(2);
    rd(8'h10, v); chk("R9 edge latched", v, 32'h0000_0020);
    wr(8'h02, 5);
    rd(8'h10, v); chk("R9 edge cleared", v, 32'h0);

    // R9 polarity
    wr(8'h18, ~32'h0000_0040);
    rd(8'h10, v); chk("R9 active low", v, 32'h0000_0040);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h12, 32'h0000_0040);
    rd(8'h10, v); chk("R5 w1c group0", v, 32'h0);

    // R4 out-of-range numbers ignored
    wr(8'h01, 64);
    rd(8'h10, v); chk("R4 set 64 g0", v, 32'h0);
    rd(8'h11, v); chk("R4 set 64 g1", v, 32'h0);
    wr(8'h03, 64);
    rd(8'h14, v); chk("R4 enable 64", v, 32'h0000_0028);

    // R6 / R7 / R10 gating and latency
    wr(8'h01, 5);
    idle(2);
    chk("R10 pending again", 32'(host_irq), 32'h008);
    wr(8'h06, 3); idle(2);
    chk("R6 host disabled", 32'(host_irq), 32'h0);
    wr(8'h06, 12); wr(8'h05, 12); idle(2);
    chk("R6 host 12 ignored", 32'(host_irq), 32'h0);
    wr(8'h05, 3); idle(2);
    chk("R6 host enabled", 32'(host_irq), 32'h008);
    wr(8'h00, 0);
    chk("R10 one-cycle lag", 32'(host_irq), 32'h008);
    @(negedge clk);
    chk("R7 global off", 32'(host_irq), 32'h0);
    wr(8'h00, 1);
    chk("R10 lag on rise", 32'(host_irq), 32'h0);
    @(negedge clk);
    chk("R7 global on", 32'(host_irq), 32'h008);
    wr(8'h16, 32'h0000_0020);
    rd(8'h14, v); chk("R5 enable clear", v, 32'h0000_0008);
    idle(2);
    chk("R10 disabled event", 32'(host_irq), 32'h0);
    finish_run();
  end
endmodule